// File: doc/BRIEF.md
# Latched Parallel-to-Serial Shift Register

This block turns a parallel word into a serial bit stream through two stages. A bank of level-sensitive holding latches sits in front of a shift register. While the latch-open control is low, the bank passes the parallel pins straight through. When that control rises, the bank keeps the word it was passing, and later pin changes do not reach it. The shift register takes its parallel word only from the latch bank and never from the pins. It can be loaded or cleared by level-sensitive controls. It shifts toward a single serial output on each rising edge of an external shift clock.

Everything runs on one system clock. The external shift clock is passed through a synchronizer, and its rising edge becomes an internal shift strobe. Load and clear are sampled on every system cycle, and either one overrides a shift strobe that falls in the same cycle. If load and clear are asserted together, the register is cleared and a flag output reports the conflict.

The output is the most significant stage, so the bit from parallel input WIDTH-1 appears first. Bits from the serial input follow after the word. Because of this, the serial output of one instance can drive the serial input of the next, and the chain acts as one longer shifter. The handshake style does not fit these pins, so there is no valid/ready and no back-pressure. A consumer samples the serial output after each shift-clock rising edge, and nothing can stall the block.

Top module: `latched_piso`

## Requirements
- R1: Under the active-low reset `rst_n`, the latch bank and the shift register both clear to zero, and `ser_out` and `ctrl_conflict` read 0.
- R2: While `lat_open_n` is low, the latch bank is transparent, so a load copies the value present on `par_d` at that moment.
- R3: When `lat_open_n` rises, the bank keeps the `par_d` value from the last cycle it was low, and later changes on `par_d` have no effect while it stays high.
- R4: A cycle with `load_n` low and `clr_n` high copies the latch bank into the shift register at the next clock edge, and `ser_out` then shows bit WIDTH-1 of the latched word.
- R5: A cycle with `clr_n` low and `load_n` high forces every stage to zero at the next clock edge.
- R6: With `load_n` and `clr_n` high, each rising edge of `shift_clk` moves stage n into stage n+1 and `ser_in` into stage 0, within three system cycles of the edge. After a load, the word leaves MSB first, followed by the `ser_in` bits in the order they were shifted in.
- R7: Load and clear take priority over a shift strobe that falls in the same cycle.
- R8: A cycle with `load_n` and `clr_n` both low clears the shift register, and `ctrl_conflict` is high in the following cycle. In every other case `ctrl_conflict` is low.
- R9: The latch bank can capture a new word while a previous word is shifting out, and the serial stream is not disturbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| par_d | input | WIDTH | Parallel data into the latch bank |
| lat_open_n | input | 1 | Low: latches transparent; high: latches hold |
| load_n | input | 1 | Active-low level load from latch bank |
| clr_n | input | 1 | Active-low level clear of shift register |
| ser_in | input | 1 | Serial input into stage 0 |
| shift_clk | input | 1 | External shift clock, rising edge shifts |
| ser_out | output | 1 | Serial output, last stage |
| ctrl_conflict | output | 1 | High the cycle after load and clear were both low |

## Verification
The bench builds the block with WIDTH = 8 and SYNC_STAGES = 2. With these values a full word plus eight trailing serial-input bits fits into short shift sequences, and the three-cycle strobe latency can be predicted exactly. This lets the bench hold a load across a shift-clock edge and see load win. It can also reopen the latches in the middle of a word and confirm that the serial stream continues unchanged while a two-device cascade pattern passes through.

// File: rtl/psr_pkg.sv
package psr_pkg;

  typedef enum logic [2:0] {
    OP_HOLD,
    OP_SHIFT,
    OP_LOAD,
    OP_CLEAR,
    OP_CONFLICT
  } sr_op_e;

  // Priority: conflict > clear > load > shift > hold
  function automatic sr_op_e pick_op(input logic load_n, input logic clr_n,
                                     input logic shift_en);
    sr_op_e op;
    if (!load_n && !clr_n)      op = OP_CONFLICT;
    else if (!clr_n)            op = OP_CLEAR;
    else if (!load_n)           op = OP_LOAD;
    else if (shift_en)          op = OP_SHIFT;
    else                        op = OP_HOLD;
    return op;
  endfunction

endpackage

// File: rtl/psr_edge_sync.sv
module psr_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  localparam int LAST = STAGES;

  // chain_q[0..STAGES-1] synchronize, chain_q[STAGES] holds prior value
  logic [LAST:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[LAST-1:0], async_in};
  end

  assign rise = chain_q[LAST-1] & ~chain_q[LAST];
endmodule

// File: rtl/psr_latch_bank.sv
module psr_latch_bank #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             open_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] held_q;

  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       held_q[i] <= 1'b0;
      else if (!open_n) held_q[i] <= d[i];
    end
    // transparent path while open, stored value otherwise
    assign q[i] = open_n ? held_q[i] : d[i];
  end
endmodule

// File: rtl/psr_shifter.sv
module psr_shifter #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_n,
  input  logic             clr_n,
  input  logic             shift_en,
  input  logic             ser_in,
  input  logic [WIDTH-1:0] par_in,
  output logic [WIDTH-1:0] stages_q,
  output logic             conflict_q
);
  import psr_pkg::*;

  sr_op_e op;
  always_comb op = pick_op(load_n, clr_n, shift_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stages_q   <= '0;
      conflict_q <= 1'b0;
    end else begin
      conflict_q <= (op == OP_CONFLICT);
      case (op)
        OP_LOAD:               stages_q <= par_in;
        OP_CLEAR, OP_CONFLICT: stages_q <= '0;
        OP_SHIFT:              stages_q <= {stages_q[WIDTH-2:0], ser_in};
        default:               stages_q <= stages_q;
      endcase
    end
  end
endmodule

// File: rtl/latched_piso.sv
module latched_piso #(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] par_d,
  input  logic             lat_open_n,
  input  logic             load_n,
  input  logic             clr_n,
  input  logic             ser_in,
  input  logic             shift_clk,
  output logic             ser_out,
  output logic             ctrl_conflict
);
  localparam int MSB = WIDTH - 1;

  logic             shift_en;
  logic [WIDTH-1:0] latch_q;
  logic [WIDTH-1:0] shreg_q;

  psr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(shift_clk), .rise(shift_en)
  );

  psr_latch_bank #(.WIDTH(WIDTH)) u_latch (
    .clk(clk), .rst_n(rst_n), .open_n(lat_open_n), .d(par_d), .q(latch_q)
  );

  psr_shifter #(.WIDTH(WIDTH)) u_shift (
    .clk(clk), .rst_n(rst_n), .load_n(load_n), .clr_n(clr_n),
    .shift_en(shift_en), .ser_in(ser_in), .par_in(latch_q),
    .stages_q(shreg_q), .conflict_q(ctrl_conflict)
  );

  assign ser_out = shreg_q[MSB];
endmodule

// File: rtl/psr_checker.sv
module psr_checker #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lat_open_n,
  input logic             load_n,
  input logic             clr_n,
  input logic             ser_in,
  input logic             ser_out,
  input logic             ctrl_conflict,
  input logic             shift_en,
  input logic [WIDTH-1:0] latch_q,
  input logic [WIDTH-1:0] shreg_q
);
  a_r3_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && lat_open_n && $past(lat_open_n)) |-> $stable(latch_q));

  a_r4_load_copies: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_n && clr_n) |=> (shreg_q == $past(latch_q) && ser_out == $past(latch_q[WIDTH-1])));

  a_r5_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_n && load_n) |=> (shreg_q == '0 && !ser_out));

  a_r6_shift_step: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && load_n && clr_n) |=> shreg_q == {$past(shreg_q[WIDTH-2:0]), $past(ser_in)});

  a_r8_conflict_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_n && !clr_n) |=> (ctrl_conflict && shreg_q == '0));

  a_r8_no_false_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n || clr_n) |=> !ctrl_conflict);
endmodule

bind latched_piso psr_checker #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .lat_open_n(lat_open_n), .load_n(load_n),
  .clr_n(clr_n), .ser_in(ser_in), .ser_out(ser_out),
  .ctrl_conflict(ctrl_conflict), .shift_en(shift_en),
  .latch_q(latch_q), .shreg_q(shreg_q)
);

// File: tb/latched_piso_tb_top.sv
module latched_piso_tb_top;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] par_d = '0;
  logic         lat_open_n = 1'b1;
  logic         load_n = 1'b1;
  logic         clr_n = 1'b1;
  logic         ser_in = 1'b0;
  logic         shift_clk = 1'b0;
  logic         ser_out;
  logic         ctrl_conflict;

  always #2.5 clk = ~clk;  // 200 MHz

  latched_piso #(.WIDTH(W), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .par_d(par_d), .lat_open_n(lat_open_n),
    .load_n(load_n), .clr_n(clr_n), .ser_in(ser_in), .shift_clk(shift_clk),
    .ser_out(ser_out), .ctrl_conflict(ctrl_conflict)
  );

  typedef struct { logic ser; logic conf; string tag; } exp_t;
  exp_t exp_q[$];
  int n_cmp = 0, n_bad = 0;
  logic [W-1:0] lat_model = '0, sr_model = '0;
  bit done = 0;

  // monitor: compare at falling edge
  always @(negedge clk) begin
    while (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      n_cmp++;
      if (ser_out !== e.ser || ctrl_conflict !== e.conf) begin
        n_bad++;
        $display("FAIL %s: actual ser_out=%b conflict=%b expected ser_out=%b conflict=%b",
                 e.tag, ser_out, ctrl_conflict, e.ser, e.conf);
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic push(input logic s, input logic c, input string tag);
    exp_t e;
    e.ser = s; e.conf = c; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic capture(input logic [W-1:0] d);
    lat_open_n = 1'b0; par_d = d; tick();
    lat_open_n = 1'b1; tick();
    lat_model = d;
  endtask

  task automatic do_load(input string tag);
    load_n = 1'b0; tick(); load_n = 1'b1;
    sr_model = lat_model;
    push(sr_model[W-1], 1'b0, tag);
  endtask

  task automatic do_shift(input logic si, input string tag);
    ser_in = si; shift_clk = 1'b1;
    repeat (4) tick();
    shift_clk = 1'b0;
    repeat (4) tick();
    sr_model = {sr_model[W-2:0], si};
    push(sr_model[W-1], 1'b0, tag);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog (all requirements): actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    par_d = 8'hA5;
    repeat (3) tick();
    push(1'b0, 1'b0, "R1 reset outputs");
    tick();
    rst_n = 1'b1; tick();
    // R1/R3: latch held at reset value 0 despite par_d=A5
    do_load("R1 latch cleared");
    for (int i = 0; i < W-1; i++) do_shift(1'b0, "R1 zero word");

    // R2: transparent load
    lat_open_n = 1'b0; par_d = 8'h3C; tick();
    lat_model = 8'h3C;
    do_load("R2 transparent load");
    lat_open_n = 1'b1; tick();
    for (int i = 0; i < W-1; i++) do_shift(1'b0, "R4 word 3C msb first");

    // R3: capture then ignore pin changes
    capture(8'hC3);
    par_d = 8'h5A; repeat (3) tick();
    do_load("R3 hold after capture");
    // R6: word then ser_in bits (cascade pattern)
    begin
      logic [W-1:0] pat = 8'b1011_0010;
      for (int i = 0; i < 2*W; i++)
        do_shift(pat[W-1 - (i % W)], "R6 shift and cascade");
    end

    // R5: clear
    capture(8'hFF);
    do_load("R4 load FF");
    clr_n = 1'b0; tick(); clr_n = 1'b1;
    sr_model = '0; push(1'b0, 1'b0, "R5 clear");
    for (int i = 0; i < 3; i++) do_shift(1'b0, "R5 cleared stages");

    // R7: load held across a shift strobe
    capture(8'h81);
    load_n = 1'b0; shift_clk = 1'b1; ser_in = 1'b0;
    repeat (4) tick();
    shift_clk = 1'b0; repeat (2) tick();
    load_n = 1'b1; tick();
    sr_model = lat_model; push(sr_model[W-1], 1'b0, "R7 load over shift");
    for (int i = 0; i < W-1; i++) do_shift(1'b1, "R7 word 81");
    // R7: clear held across a shift strobe
    clr_n = 1'b0; shift_clk = 1'b1; ser_in = 1'b1;
    repeat (4) tick();
    shift_clk = 1'b0; repeat (2) tick();
    clr_n = 1'b1; tick();
    sr_model = '0; push(1'b0, 1'b0, "R7 clear over shift");

    // R8: conflict
    capture(8'hF0);
    do_load("R4 load F0");
    load_n = 1'b0; clr_n = 1'b0; tick();
    push(1'b0, 1'b1, "R8 conflict flag and clear");
    load_n = 1'b1; clr_n = 1'b1; tick();
    push(1'b0, 1'b0, "R8 flag drops");
    sr_model = '0;
    do_shift(1'b0, "R8 register cleared");

    // R9: capture during shifting
    capture(8'h96);
    do_load("R4 load 96");
    for (int i = 0; i < 3; i++) do_shift(1'b0, "R9 stream before capture");
    lat_open_n = 1'b0; par_d = 8'h0F; tick(); tick();
    lat_open_n = 1'b1; par_d = 8'h00; tick();
    lat_model = 8'h0F;
    for (int i = 0; i < 4; i++) do_shift(1'b0, "R9 stream undisturbed");
    do_load("R9 new word loaded");
    for (int i = 0; i < W-1; i++) do_shift(1'b0, "R9 word 0F");

    repeat (3) tick();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule